// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches a word that arrives on dual-rail wires, a true rail and a false rail for every bit, and reports a single completion flag. A bit is counted as present as soon as either of its rails is high. The per-bit presence signals are merged by a multi-input Muller C-element. The element switches its output to 1 once every bit is present and switches it to 0 once every bit has gone back to the empty (spacer) state. In every other mix it keeps the value it already has. The flag therefore marks both the end of a data wave and the end of the return-to-zero wave that follows it.

The C-element's memory is a clocked register, so the block can be synthesized and sits inside a synchronous design. The block also presents the true rails as the decoded single-rail word, which is meaningful while done is 1. It raises an error flag whenever any bit has both of its rails high.

Top module: `dr_completion_detect`

## Requirements
- R1: After a clock edge with `rst_n` low, `done` is 0, whatever the rails carry.
- R2: When every bit is present (`rail_t[i] | rail_f[i]` is 1 for all i) at a rising clock edge, `done` is 1 after that edge.
- R3: When every bit is in the spacer state (both rails 0 for all i) at a rising clock edge, `done` is 0 after that edge.
- R4: When some bits are present and others are spacer at a rising clock edge, `done` keeps its value across that edge.
- R5: `data` equals `rail_t` at all times. Per bit, the encoding {t,f} is 00 for spacer, 10 for logic 1 and 01 for logic 0.
- R6: `err` is 1 while any bit carries {t,f} = 11 and 0 otherwise, with no clock delay. Such a bit still counts as present for R2 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the C-element state register |
| rst_n | input | 1 | Synchronous reset, active low |
| rail_t | input | N | True rail of each bit |
| rail_f | input | N | False rail of each bit |
| done | output | 1 | Completion flag: 1 after all bits present, 0 after all bits spacer |
| data | output | N | Decoded single-rail word (the true rails) |
| err | output | 1 | Some bit has both rails high |

## Verification
The bench goes after the hysteresis. A partly filled or partly emptied word follows both a full word and an empty word. An AND-tree design would drop `done` early during the return-to-zero wave, and an OR-tree design would raise it early during the data wave. It also sends an all-zero data word and a word holding an illegal 11 bit. A design that took only the true rails as validity, or that left illegal bits out of validity, would never complete on these words. Reset is applied while the word is full, to show that reset overrides a set condition, and a partial word is held after reset to show that nothing was left over from before.

// File: rtl/dr_pkg.sv
// Package: shared types for the dual-rail completion detector.
// Assumes: each bit is carried as a {t,f} rail pair.
package dr_pkg;

    // Decoded meaning of one rail pair
    typedef enum logic [1:0] {
        DR_SPACER = 2'b00,
        DR_ZERO   = 2'b01,
        DR_ONE    = 2'b10,
        DR_BAD    = 2'b11
    } dr_code_e;

    // Per-bit decode result
    typedef struct packed {
        logic present;
        logic value;
        logic illegal;
    } dr_bit_t;

endpackage

// File: rtl/dr_bit_decode.sv
// Module: dr_bit_decode
// Turns one {t,f} rail pair into a presence flag (OR of rails), the
// single-rail value (true rail) and an illegal flag (both rails high).
// Assumes: purely combinational; rails may change at any time.
module dr_bit_decode
    import dr_pkg::*;
(
    input  logic    rt,
    input  logic    rf,
    output dr_bit_t dec
);

    dr_code_e code;

    // Classify the rail pair and fill the decode record
    always_comb begin
        code        = dr_code_e'({rt, rf});
        dec.present = rt | rf;
        dec.value   = rt;
        dec.illegal = (code == DR_BAD);
    end

endmodule

// File: rtl/dr_celem.sv
// Module: dr_celem
// Multi-input Muller C-element modelled as a clocked hold register:
// goes to 1 when all inputs are 1, to 0 when all inputs are 0, else holds.
// Assumes: synchronous active-low reset clears the state to 0.
module dr_celem #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in,
    output logic         q
);

    logic all_hi;
    logic all_lo;
    logic q_nxt;

    // Decide the next state from the unanimity of the inputs
    always_comb begin
        all_hi = &in;
        all_lo = ~|in;
        if (all_hi)      q_nxt = 1'b1;
        else if (all_lo) q_nxt = 1'b0;
        else             q_nxt = q;
    end

    // Hold register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_nxt;
    end

endmodule

// File: rtl/dr_completion_detect.sv
// Module: dr_completion_detect (top)
// Completion detection for an N-bit dual-rail word: per-bit rail ORs are
// merged by a C-element, giving done for all-present and all-spacer waves.
// Also outputs the decoded word and an illegal-code flag.
// Assumes: rails are stable around the clock edge; data valid while done=1.
module dr_completion_detect
    import dr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rail_t,
    input  logic [N-1:0] rail_f,
    output logic         done,
    output logic [N-1:0] data,
    output logic         err
);

    localparam int LAST = N - 1;

    dr_bit_t [LAST:0] dec;
    logic    [LAST:0] present;
    logic    [LAST:0] illegal;

    // One decoder per bit
    for (genvar i = 0; i < N; i++) begin : g_bit
        dr_bit_decode u_dec (
            .rt  (rail_t[i]),
            .rf  (rail_f[i]),
            .dec (dec[i])
        );
        assign present[i] = dec[i].present;
        assign illegal[i] = dec[i].illegal;
        assign data[i]    = dec[i].value;
    end

    // Merge of per-bit presence
    dr_celem #(.W(N)) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .in    (present),
        .q     (done)
    );

    // Flag any bit carrying the illegal code
    always_comb begin
        err = |illegal;
    end

endmodule

// File: rtl/dr_completion_chk.sv
// Module: dr_completion_chk
// Checker for dr_completion_detect, attached with bind below.
// Assumes: it sees only the top-level ports.
module dr_completion_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] rail_t,
    input logic [N-1:0] rail_f,
    input logic         done
);

    logic [N-1:0] pres;
    assign pres = rail_t | rail_f;

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !done); // R1
    AST_SET_ON_FULL:  assert property (@(posedge clk) disable iff (!rst_n) (&pres) |=> done); // R2
    AST_CLR_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (~|pres) |=> !done); // R3
    AST_HOLD_ON_MIX:  assert property (@(posedge clk) disable iff (!rst_n) (!(&pres) && (|pres)) |=> $stable(done)); // R4

endmodule

bind dr_completion_detect dr_completion_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rail_t (rail_t),
    .rail_f (rail_f),
    .done   (done)
);

// File: tb/sim_dr_completion_detect.sv
// Bench for dr_completion_detect: table walk, then directed reset cases.
module sim_dr_completion_detect;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] rail_t;
    logic [N-1:0] rail_f;
    logic         done;
    logic [N-1:0] data;
    logic         err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dr_completion_detect #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .rail_t(rail_t), .rail_f(rail_f),
        .done(done), .data(data), .err(err)
    );

    // {rail_t, rail_f, done after edge, err}
    localparam int NV = 14;
    localparam logic [17:0] VEC [NV] = '{
        {8'h00, 8'h00, 1'b0, 1'b0},  // R3 empty
        {8'h0F, 8'h00, 1'b0, 1'b0},  // R4 partial, hold 0
        {8'h0F, 8'hF0, 1'b1, 1'b0},  // R2 full
        {8'h0F, 8'h00, 1'b1, 1'b0},  // R4 partial, hold 1
        {8'h00, 8'h00, 1'b0, 1'b0},  // R3
        {8'hAA, 8'h55, 1'b1, 1'b0},  // R2
        {8'hAA, 8'h54, 1'b1, 1'b0},  // R4 one bit back to spacer
        {8'h00, 8'h01, 1'b1, 1'b0},  // R4 one bit left
        {8'h00, 8'h00, 1'b0, 1'b0},  // R3
        {8'h00, 8'hFF, 1'b1, 1'b0},  // R2 all-zero word
        {8'h00, 8'h00, 1'b0, 1'b0},  // R3
        {8'h01, 8'h00, 1'b0, 1'b0},  // R4
        {8'hFF, 8'h01, 1'b1, 1'b1},  // R6 illegal bit counts present
        {8'h00, 8'h00, 1'b0, 1'b0}   // R3
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge, check comb outputs, clock, check done
    task automatic apply(input logic [N-1:0] t, input logic [N-1:0] f,
                         input logic ed, input logic ee, input string req);
        @(negedge clk);
        rail_t = t;
        rail_f = f;
        #1;
        check("R5 data", data, t);
        check("R6 err", {{(N-1){1'b0}}, err}, {{(N-1){1'b0}}, ee});
        @(posedge clk);
        #1;
        check(req, {{(N-1){1'b0}}, done}, {{(N-1){1'b0}}, ed});
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        rail_t = '1;
        rail_f = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset", {{(N-1){1'b0}}, done}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0], "R2/R3/R4 table");
        end

        // Reset while full: R1 overrides set
        apply(8'hC3, 8'h3C, 1'b1, 1'b0, "R2 full before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset over full", {{(N-1){1'b0}}, done}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        rail_t = 8'h03;
        rail_f = 8'h00;
        @(posedge clk);
        #1;
        check("R4 partial after reset", {{(N-1){1'b0}}, done}, '0);
        apply(8'h03, 8'hFC, 1'b1, 1'b0, "R2 full after reset");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule